// File: doc/BRIEF.md
# Maskable Calendar Alarm Comparator

This block watches a running calendar (minute, hour, day of month, weekday, all packed BCD) and raises a sticky alarm flag when every alarm field that is switched on equals the matching calendar field. The comparison runs only on a one-cycle strobe that marks the start of a new minute, so the alarm resolves to the minute and one match sets the flag once.

Software reaches four alarm bytes and one control byte through a simple synchronous register port. Each alarm byte carries a disable bit that takes its field out of the comparison. The control byte holds the flag and an interrupt enable. The interrupt pin is active low and level sensitive: it stays low until software clears the flag or drops the enable. The calendar counters and the serial bus that would feed the register port are outside the block.

Top module: `cal_alarm_match`

## Requirements
- R1: After reset all four alarm bytes read 0x80, the control byte reads 0x00 and irq_n is high.
- R2: Alarm bytes sit at addresses 0x9 (minute), 0xA (hour), 0xB (day of month) and 0xC (weekday) and read back as written. The compared bits are the low 7 for minute, low 6 for hour and day, and low 3 for weekday.
- R3: The calendar is compared only in a cycle where minute_tick is 1. A match becomes visible in the flag on the clock edge that samples the strobe.
- R4: Bit 7 of an alarm byte set to 1 removes that field from the comparison. A match needs every remaining field to be equal.
- R5: In the control byte at address 0x1, bit 3 is the alarm flag and bit 1 is the interrupt enable. Writing the control byte with bit 3 at 0 clears the flag.
- R6: irq_n is low exactly while the flag and the interrupt enable are both 1.
- R7: Writing 1 to control bit 3 never sets the flag.
- R8: With all four alarm bytes disabled, no strobe ever sets the flag.
- R9: A match on the same edge as a clearing control write leaves the flag set.
- R10: Once set, the flag stays set across later strobes, matching or not, until software clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| minute_tick | input | 1 | One-cycle strobe at each minute boundary |
| cur_min | input | 8 | Current minute, BCD |
| cur_hour | input | 8 | Current hour, BCD |
| cur_mday | input | 8 | Current day of month, BCD |
| cur_wday | input | 8 | Current weekday, BCD |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| irq_n | output | 1 | Alarm interrupt, active low, level |

## Verification
The embedded assertions watch the flag register every cycle: it may rise only after a strobe, it never rises with every field disabled or without a full match, it survives later strobes until a clearing write, and a match wins over a simultaneous clear. Whether the field masks cut at the right bit, whether a disabled field with a differing value is really ignored, and whether the register addresses decode as stated can only be shown by the bench scenarios. The bench model predicts the pin level and the read data every cycle.

// File: rtl/alm_pkg.sv
`timescale 1ns/1ps
// Shared constants for the calendar alarm comparator.
// Assumes byte-wide registers and four alarm fields in the order
// minute, hour, day of month, weekday.
package alm_pkg;
    localparam int DW       = 8;
    localparam int NF       = 4;
    localparam int AW       = 4;
    localparam logic [AW-1:0] CTRL_ADDR = 4'h1;
    localparam logic [AW-1:0] ALM_BASE  = 4'h9;
    localparam int FLAG_BIT = 3;
    localparam int IE_BIT   = 1;
    localparam int DIS_BIT  = 7;
    localparam logic [DW-1:0] ALM_RESET = 8'h80;

    // Bits that take part in the comparison for field idx
    function automatic logic [DW-1:0] fld_mask(input int idx);
        case (idx)
            0:       fld_mask = 8'h7F;
            1:       fld_mask = 8'h3F;
            2:       fld_mask = 8'h3F;
            default: fld_mask = 8'h07;
        endcase
    endfunction
endpackage

// File: rtl/alm_field_cmp.sv
`timescale 1ns/1ps
// One alarm field compare. Reports whether the field is switched on and
// whether it is satisfied (disabled fields are always satisfied).
// Assumes both bytes are packed BCD; bits outside MASK are ignored.
module alm_field_cmp #(
    parameter int DW = 8,
    parameter logic [DW-1:0] MASK = 8'h7F,
    parameter int DIS = 7
) (
    input  logic [DW-1:0] alarm_byte,
    input  logic [DW-1:0] cur_byte,
    output logic          fld_en,
    output logic          fld_hit
);
    // Field enable and masked equality
    always_comb begin
        fld_en  = !alarm_byte[DIS];
        fld_hit = !fld_en || ((cur_byte & MASK) == (alarm_byte & MASK));
    end
endmodule

// File: rtl/alm_regs.sv
`timescale 1ns/1ps
// Register store for the alarm bytes and the interrupt enable, plus the
// read mux. Produces a clear request for the flag on a control write with
// the flag bit at 0. Assumes writes take effect on the next clock edge.
module alm_regs
    import alm_pkg::*;
#(
    parameter int N = NF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    input  logic                flag,
    output logic [N-1:0][DW-1:0] alarm_q,
    output logic                ie_q,
    output logic                clr_req,
    output logic [DW-1:0]       reg_rdata
);
    logic ctrl_sel;
    assign ctrl_sel = (reg_addr == CTRL_ADDR);

    // Alarm byte and enable storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) alarm_q[i] <= ALM_RESET;
            ie_q <= 1'b0;
        end else if (reg_wr) begin
            if (ctrl_sel) ie_q <= reg_wdata[IE_BIT];
            for (int i = 0; i < N; i++)
                if (reg_addr == ALM_BASE + AW'(i)) alarm_q[i] <= reg_wdata;
        end
    end

    // Clear request: control write carrying a 0 in the flag position
    assign clr_req = reg_wr && ctrl_sel && !reg_wdata[FLAG_BIT];

    // Read mux
    always_comb begin
        reg_rdata = '0;
        if (ctrl_sel) begin
            reg_rdata[FLAG_BIT] = flag;
            reg_rdata[IE_BIT]   = ie_q;
        end
        for (int i = 0; i < N; i++)
            if (reg_addr == ALM_BASE + AW'(i)) reg_rdata = alarm_q[i];
    end
endmodule

// File: rtl/alm_flag.sv
`timescale 1ns/1ps
// Sticky alarm flag. Set by a full match on the minute strobe, cleared by
// software; a set on the same edge as a clear wins.
// Assumes tick is a single-cycle strobe.
module alm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic any_en,
    input  logic all_hit,
    input  logic clr_req,
    output logic flag
);
    logic set_ev;
    assign set_ev = tick && any_en && all_hit;

    // Flag register with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_ev)  flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick)); // R3
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag); // R10
    AST_ALL_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !any_en) |=> !flag); // R8
    AST_SW_CANNOT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(tick && all_hit)) |=> !flag); // R7
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && any_en && all_hit && clr_req) |=> flag); // R9
endmodule

// File: rtl/cal_alarm_match.sv
`timescale 1ns/1ps
// Calendar alarm comparator top. Compares four BCD calendar fields with
// four alarm bytes on each minute strobe and drives an active-low level
// interrupt from the sticky flag and its enable.
// Assumes calendar inputs are stable while minute_tick is high.
module cal_alarm_match
    import alm_pkg::*;
#(
    parameter int N = NF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          minute_tick,
    input  logic [DW-1:0] cur_min,
    input  logic [DW-1:0] cur_hour,
    input  logic [DW-1:0] cur_mday,
    input  logic [DW-1:0] cur_wday,
    input  logic          reg_wr,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          irq_n
);
    logic [N-1:0][DW-1:0] alarm_q;
    logic [N-1:0][DW-1:0] cur_f;
    logic [N-1:0]         en_v;
    logic [N-1:0]         hit_v;
    logic                 ie_q, clr_req, flag;

    assign cur_f = {cur_wday, cur_mday, cur_hour, cur_min};

    alm_regs #(.N(N)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .flag(flag), .alarm_q(alarm_q), .ie_q(ie_q),
        .clr_req(clr_req), .reg_rdata(reg_rdata)
    );

    for (genvar g = 0; g < N; g++) begin : g_fld
        alm_field_cmp #(.DW(DW), .MASK(fld_mask(g)), .DIS(DIS_BIT)) u_cmp (
            .alarm_byte(alarm_q[g]), .cur_byte(cur_f[g]),
            .fld_en(en_v[g]), .fld_hit(hit_v[g])
        );
    end

    alm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .tick(minute_tick), .any_en(|en_v),
        .all_hit(&hit_v), .clr_req(clr_req), .flag(flag)
    );

    // Level-low interrupt
    assign irq_n = !(flag && ie_q);

    AST_IRQ_FOLLOWS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_q) |-> irq_n); // R6
endmodule

// File: tb/test_cal_alarm_match.sv
`timescale 1ns/1ps
module test_cal_alarm_match;
    logic       clk = 0, rst_n = 0, minute_tick = 0, reg_wr = 0;
    logic [7:0] cur_min = 0, cur_hour = 0, cur_mday = 0, cur_wday = 0;
    logic [3:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic       irq_n;

    cal_alarm_match i_cal_alarm_match (.*);

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit chk_en = 0;
    bit [7:0] m_alm [4];
    bit m_ie, m_flag;
    int msk [4] = '{8'h7F, 8'h3F, 8'h3F, 8'h07};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Behavioural reference model
    always @(posedge clk) begin
        int cur [4];
        int en_cnt;
        bit ev;
        cyc++;
        cur = '{int'(cur_min), int'(cur_hour), int'(cur_mday), int'(cur_wday)};
        if (!rst_n) begin
            foreach (m_alm[i]) m_alm[i] = 8'h80;
            m_ie = 0; m_flag = 0;
        end else begin
            ev = minute_tick; en_cnt = 0;
            foreach (m_alm[i]) if (!m_alm[i][7]) begin
                en_cnt++;
                if ((cur[i] & msk[i]) != (int'(m_alm[i]) & msk[i])) ev = 0;
            end
            if (en_cnt == 0) ev = 0;
            if (ev) m_flag = 1;
            else if (reg_wr && reg_addr == 4'h1 && !reg_wdata[3]) m_flag = 0;
            if (reg_wr) begin
                if (reg_addr == 4'h1) m_ie = reg_wdata[1];
                if (reg_addr >= 4'h9 && reg_addr <= 4'hC) m_alm[reg_addr - 4'h9] = reg_wdata;
            end
        end
    end

    // Per-cycle comparison, away from the edge
    always @(posedge clk) begin
        int exp_rd;
        #5;
        if (chk_en) begin
            check(irq_n == !(m_flag && m_ie), "R6 model irq_n", irq_n, !(m_flag && m_ie));
            exp_rd = 0;
            if (reg_addr == 4'h1) exp_rd = (m_flag << 3) | (m_ie << 1);
            if (reg_addr >= 4'h9 && reg_addr <= 4'hC) exp_rd = m_alm[reg_addr - 4'h9];
            check(reg_rdata == exp_rd, "R2 model rdata", reg_rdata, exp_rd);
        end
    end

    // Watchdog
    always @(posedge clk) if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_addr = 0;
    endtask

    task automatic set_time(input logic [7:0] mi, h, d, w);
        cur_min = mi; cur_hour = h; cur_mday = d; cur_wday = w;
    endtask

    task automatic tick_at(input logic [7:0] mi, h, d, w);
        @(negedge clk); set_time(mi, h, d, w); minute_tick = 1;
        @(negedge clk); minute_tick = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); reg_addr = a; #1;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    task automatic pin(input bit exp, input string req);
        @(negedge clk); #1;
        check(irq_n == exp, req, irq_n, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1; chk_en = 1;
        // R1 reset state
        for (int a = 9; a <= 12; a++) rd(a[3:0], 8'h80, "R1 alarm reset");
        rd(4'h1, 8'h00, "R1 ctrl reset");
        pin(1, "R1 irq_n reset");
        // R2 / R3 minute-only alarm
        wr(4'h9, 8'h30); wr(4'h1, 8'h02);
        rd(4'h9, 8'h30, "R2 minute readback");
        @(negedge clk); set_time(8'h30, 8'h12, 8'h05, 8'h02);
        repeat (3) @(negedge clk);
        pin(1, "R3 no strobe no flag");
        tick_at(8'h30, 8'h12, 8'h05, 8'h02);
        pin(0, "R3 match sets flag");
        rd(4'h1, 8'h0A, "R5 ctrl shows flag and enable");
        // R10 sticky
        tick_at(8'h31, 8'h12, 8'h05, 8'h02);
        pin(0, "R10 flag held");
        // R5 clear, R7 write-one
        wr(4'h1, 8'h02);
        pin(1, "R5 clear releases irq");
        wr(4'h1, 8'h0A);
        rd(4'h1, 8'h02, "R7 write one no set");
        // R4 all four fields
        wr(4'h9, 8'h15); wr(4'hA, 8'h07); wr(4'hB, 8'h21); wr(4'hC, 8'h03);
        rd(4'hC, 8'h03, "R2 weekday readback");
        tick_at(8'h15, 8'h08, 8'h21, 8'h03);
        pin(1, "R4 hour mismatch");
        tick_at(8'h15, 8'h07, 8'h21, 8'h03);
        pin(0, "R4 full match");
        wr(4'h1, 8'h02);
        // R4 disabled weekday ignored; R2 upper bits outside mask ignored
        wr(4'hC, 8'h83);
        tick_at(8'h95, 8'hC7, 8'hE1, 8'h05);
        pin(0, "R4 disabled field ignored");
        wr(4'h1, 8'h02);
        // R8 all disabled, even with zero time
        for (int a = 9; a <= 12; a++) wr(a[3:0], 8'h80);
        tick_at(8'h00, 8'h00, 8'h00, 8'h00);
        pin(1, "R8 all disabled");
        rd(4'h1, 8'h02, "R8 flag stays clear");
        // R6 enable gating
        wr(4'hA, 8'h23); wr(4'h1, 8'h00);
        tick_at(8'h00, 8'h23, 8'h00, 8'h00);
        pin(1, "R6 masked by enable");
        rd(4'h1, 8'h08, "R6 flag set without enable");
        wr(4'h1, 8'h0A);
        pin(0, "R6 enable drives irq");
        wr(4'h1, 8'h02);
        // R9 set beats clear on the same edge
        @(negedge clk); set_time(8'h00, 8'h23, 8'h00, 8'h00);
        minute_tick = 1; reg_wr = 1; reg_addr = 4'h1; reg_wdata = 8'h02;
        @(negedge clk); minute_tick = 0; reg_wr = 0;
        rd(4'h1, 8'h0A, "R9 set wins");
        repeat (3) @(negedge clk);
        report();
    end
endmodule